// File: doc/BRIEF.md
# Banked reset controller

This block drives a wide vector of reset lines from a small word-addressed register bus. The lines come in banks of 32. Each bank has three words: one where a write of a mask asserts lines, one where a write of a mask releases lines, and one that reads back which lines are currently held. The number of banks is a parameter. The total line count is always a whole number of banks times 32.

Each line also has its own settle timer. A block behind a released reset needs up to 14 microseconds before it can be used. The controller counts that time in clock cycles and raises a per-line ready flag only when the count is done.

Each line is a small state machine with three states: `LN_HELD` (reset driven), `LN_SETTLE` (released, timer running) and `LN_READY` (released, timer done). It has four transitions:
- HELD to SETTLE on a clear bit.
- SETTLE to READY when the count expires.
- SETTLE to HELD on a set bit.
- READY to HELD on a set bit.

Top module: `rstline_hub`

## Requirements
- R1: Line id n is driven on `rst_out[n]` and `ready_out[n]`. It belongs to bank n/32 (id bits above bit 4) and sits at bit position n%32 (id bits 4:0) within that bank's words.
- R2: Bank b starts at byte address b*0x18. Its assert word is at +0x00, its release word at +0x04 and its status word at +0x08. A write to one bank leaves every other bank unchanged.
- R3: A write to an assert word drives high (held) exactly the lines of that bank whose data bit is 1. Lines whose bit is 0 keep their state.
- R4: A write to a release word drives low exactly the lines of that bank whose data bit is 1. Lines whose bit is 0 keep their state.
- R5: `bus_rdata` is combinational from the address. At a status word it returns the bank's 32 lines, with 1 meaning held. Reads of the assert and release words return zero. Writes to a status word change nothing.
- R6: The other words in a bank (offsets 0x0C to 0x14 and any unaligned offset) and any address at or above NUM_BANKS*0x18 read as zero. Writes to them change no line.
- R7: After system reset every line is held and every ready flag is low.
- R8: A line's ready flag rises exactly SETTLE_CYCLES = CLK_MHZ*SETTLE_US clock edges after the edge that released it. This is 1750 at the default 125 MHz and 14 us. It is never earlier.
- R9: An assert bit on a settling or ready line holds the line and drops its ready flag at the same edge. A later release restarts the full count.
- R10: A release bit on a line that is already released neither restarts nor shortens its running count, and does not drop a ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data (line mask) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_out | output | NUM_BANKS*32 | Reset lines, 1 = held |
| ready_out | output | NUM_BANKS*32 | Per-line ready flags |

## Verification
The bench checks the exact edge on which a ready flag rises. An off-by-one counter would show up one cycle early or late on either side of the 1750-cycle mark.

It issues a repeated release in mid-count. A design that restarted the timer on it would still be low at the original deadline.

It asserts a line while it is ready and while it is settling. A design that kept ready high, or resumed an old count, would show a high flag on a held line.

It writes to reserved words, to the status word and to a bank past the last one. A decoder that wrapped the bank number or ignored the offset would corrupt a real bank's status.

// File: rtl/rstline_pkg.sv
package rstline_pkg;
    localparam int LINES_PER_BANK = 32;
    localparam int BANK_STRIDE    = 24;
    localparam int OFF_ASSERT     = 0;
    localparam int OFF_RELEASE    = 4;
    localparam int OFF_STATUS     = 8;

    typedef enum logic [1:0] {
        LN_HELD   = 2'd0,
        LN_SETTLE = 2'd1,
        LN_READY  = 2'd2
    } line_state_e;
endpackage

// File: rtl/rstline_decode.sv
module rstline_decode
    import rstline_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    output logic [NUM_BANKS-1:0] set_we_o,
    output logic [NUM_BANKS-1:0] clr_we_o,
    output logic                 rd_hit_o,
    output logic [BANK_W-1:0]    rd_bank_o
);
    int bank_idx;
    int offs;

    always_comb begin
        set_we_o  = '0;
        clr_we_o  = '0;
        rd_hit_o  = 1'b0;
        rd_bank_o = '0;
        bank_idx  = int'(addr_i) / BANK_STRIDE;
        offs      = int'(addr_i) % BANK_STRIDE;
        if (bank_idx < NUM_BANKS) begin
            rd_bank_o = BANK_W'(bank_idx);
            rd_hit_o  = (offs == OFF_STATUS);
            if (we_i && offs == OFF_ASSERT)  set_we_o[BANK_W'(bank_idx)] = 1'b1;
            if (we_i && offs == OFF_RELEASE) clr_we_o[BANK_W'(bank_idx)] = 1'b1;
        end
    end

    // At most one bank strobed per write, and never both words at once (R2)
    assert_one_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_we_o));
    assert_one_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_we_o));
    assert_no_dual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !((|set_we_o) && (|clr_we_o)));
    // No strobe without a bus write (R6)
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |-> (set_we_o == '0 && clr_we_o == '0));
endmodule

// File: rtl/rstline_cell.sv
module rstline_cell
    import rstline_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic line_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    line_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            LN_HELD: begin
                if (clr_i && !set_i) begin
                    st_d  = LN_SETTLE;
                    cnt_d = '0;
                end
            end
            LN_SETTLE: begin
                if (set_i)              st_d  = LN_HELD;
                else if (cnt_q == LAST) st_d  = LN_READY;
                else                    cnt_d = cnt_q + 1'b1;
            end
            LN_READY: begin
                if (set_i) st_d = LN_HELD;
            end
            default: st_d = LN_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LN_HELD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            LN_HELD:   begin line_o = 1'b1; ready_o = 1'b0; end
            LN_SETTLE: begin line_o = 1'b0; ready_o = 1'b0; end
            LN_READY:  begin line_o = 1'b0; ready_o = 1'b1; end
            default:   begin line_o = 1'b1; ready_o = 1'b0; end
        endcase
    end

    assert_set_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> line_o);
    assert_clr_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !line_o);
    assert_quiet_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(line_o));
    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !ready_o);
    assert_ready_after_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(!line_o) && !line_o));
    assert_ready_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !set_i) |=> ready_o);
endmodule

// File: rtl/rstline_bank.sv
module rstline_bank
    import rstline_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1750
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_stb_i,
    input  logic                      clr_stb_i,
    input  logic [LINES_PER_BANK-1:0] mask_i,
    output logic [LINES_PER_BANK-1:0] line_o,
    output logic [LINES_PER_BANK-1:0] ready_o
);
    for (genvar g = 0; g < LINES_PER_BANK; g++) begin : g_line
        rstline_cell #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_stb_i & mask_i[g]),
            .clr_i   (clr_stb_i & mask_i[g]),
            .line_o  (line_o[g]),
            .ready_o (ready_o[g])
        );
    end
endmodule

// File: rtl/rstline_hub.sv
module rstline_hub
    import rstline_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_US = 14
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [31:0]                         bus_wdata,
    input  logic                                bus_we,
    output logic [31:0]                         bus_rdata,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] rst_out,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] ready_out
);
    localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_BANKS-1:0]      set_we, clr_we;
    logic                      rd_hit;
    logic [BANK_W-1:0]         rd_bank;
    logic [LINES_PER_BANK-1:0] bank_line [NUM_BANKS];

    rstline_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .set_we_o  (set_we),
        .clr_we_o  (clr_we),
        .rd_hit_o  (rd_hit),
        .rd_bank_o (rd_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rstline_bank #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_stb_i (set_we[b]),
            .clr_stb_i (clr_we[b]),
            .mask_i    (bus_wdata),
            .line_o    (bank_line[b]),
            .ready_o   (ready_out[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
        assign rst_out[b*LINES_PER_BANK +: LINES_PER_BANK] = bank_line[b];
    end

    assign bus_rdata = rd_hit ? bank_line[rd_bank] : '0;

    // Reads that miss every status word return zero (R5, R6)
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= NUM_BANKS * BANK_STRIDE) |-> (bus_rdata == '0));
    // Lines never change without a bus write (R6)
    assert_no_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(rst_out));
endmodule

// File: tb/sim_rstline_hub.sv
module sim_rstline_hub;
    localparam int NL         = 64;
    localparam int EXP_SETTLE = 14 * 125;
    localparam int NV         = 23;

    // {we, req, addr, data-or-expected}
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 4'd7, 8'h08, 32'hFFFF_FFFF},  // R7 bank0 after reset
        {1'b0, 4'd7, 8'h20, 32'hFFFF_FFFF},  // R7 bank1 after reset
        {1'b1, 4'd4, 8'h04, 32'h0000_00FF},  // R4 release bank0 low byte
        {1'b0, 4'd4, 8'h08, 32'hFFFF_FF00},
        {1'b1, 4'd3, 8'h00, 32'h0000_000F},  // R3 hold four lines again
        {1'b0, 4'd3, 8'h08, 32'hFFFF_FF0F},
        {1'b1, 4'd2, 8'h1C, 32'hA5A5_0000},  // R2 bank1 release word
        {1'b0, 4'd2, 8'h20, 32'h5A5A_FFFF},
        {1'b0, 4'd2, 8'h08, 32'hFFFF_FF0F},
        {1'b1, 4'd6, 8'h0C, 32'hFFFF_FFFF},  // R6 reserved word
        {1'b0, 4'd6, 8'h08, 32'hFFFF_FF0F},
        {1'b1, 4'd6, 8'h34, 32'hFFFF_FFFF},  // R6 release in missing bank
        {1'b0, 4'd6, 8'h20, 32'h5A5A_FFFF},
        {1'b0, 4'd5, 8'h00, 32'h0000_0000},  // R5 assert word reads zero
        {1'b0, 4'd5, 8'h04, 32'h0000_0000},  // R5 release word reads zero
        {1'b0, 4'd6, 8'h10, 32'h0000_0000},  // R6 reserved reads zero
        {1'b0, 4'd6, 8'h38, 32'h0000_0000},  // R6 out of range reads zero
        {1'b1, 4'd3, 8'h18, 32'h0001_0000},  // R3 bank1 assert one bit
        {1'b0, 4'd3, 8'h20, 32'h5A5B_FFFF},
        {1'b1, 4'd6, 8'h30, 32'hFFFF_FFFF},  // R6 assert in missing bank
        {1'b0, 4'd6, 8'h20, 32'h5A5B_FFFF},
        {1'b1, 4'd5, 8'h08, 32'h0000_0000},  // R5 write to status word
        {1'b0, 4'd5, 8'h08, 32'hFFFF_FF0F}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] rst_out, ready_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rstline_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .rst_out   (rst_out),
        .ready_out (ready_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 lines held", 64'(rst_out), {64{1'b1}});
        check("R7 ready low", 64'(ready_out), 64'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                bus_write(VEC[i][39:32], VEC[i][31:0]);
            end else begin
                bus_read(VEC[i][39:32], rd);
                check($sformatf("vec %0d R%0d", i, VEC[i][43:40]), 64'(rd), 64'(VEC[i][31:0]));
            end
        end

        // R1: line n lands on rst_out[n]
        check("R1 line map", 64'(rst_out), {32'h5A5B_FFFF, 32'hFFFF_FF0F});

        // R8: release line 40 (bank1 bit 8), ready exactly EXP_SETTLE edges later
        bus_write(8'h1C, 32'h0000_0100);
        check("R8 line 40 freed", 64'(rst_out[40]), 64'd0);
        repeat (EXP_SETTLE - 1) @(negedge clk);
        check("R8 not early", 64'(ready_out[40]), 64'd0);
        @(negedge clk);
        check("R8 on time", 64'(ready_out[40]), 64'd1);

        // R1: bank0 lines 4..7 released long ago, 0..3 held
        check("R1 ready map", 64'(ready_out[7:0]), 64'h0000_0000_0000_00F0);

        // R10: release again while ready keeps ready
        bus_write(8'h1C, 32'h0000_0100);
        check("R10 ready kept", 64'(ready_out[40]), 64'd1);

        // R10: second release mid-count does not restart timer (line 41)
        bus_write(8'h1C, 32'h0000_0200);
        repeat (1000) @(negedge clk);
        bus_write(8'h1C, 32'h0000_0200);
        repeat (EXP_SETTLE - 1003) @(negedge clk);
        check("R10 not early", 64'(ready_out[41]), 64'd0);
        @(negedge clk);
        check("R10 original deadline", 64'(ready_out[41]), 64'd1);

        // R9: assert a ready line, flag drops with the hold
        bus_write(8'h18, 32'h0000_0100);
        check("R9 held again", 64'(rst_out[40]), 64'd1);
        check("R9 ready dropped", 64'(ready_out[40]), 64'd0);
        bus_write(8'h1C, 32'h0000_0100);
        repeat (EXP_SETTLE - 1) @(negedge clk);
        check("R9 full recount", 64'(ready_out[40]), 64'd0);
        @(negedge clk);
        check("R9 recount done", 64'(ready_out[40]), 64'd1);

        // R9: assert while settling (line 42) aborts the count
        bus_write(8'h1C, 32'h0000_0400);
        repeat (100) @(negedge clk);
        bus_write(8'h18, 32'h0000_0400);
        repeat (EXP_SETTLE + 10) @(negedge clk);
        check("R9 abort held", 64'(rst_out[42]), 64'd1);
        check("R9 abort no ready", 64'(ready_out[42]), 64'd0);

        finish_run();
    end
endmodule